// File: doc/BRIEF.md
# Ethernet Transmit Framer with Autopad

This block collects the bytes of one outgoing Ethernet frame from a host. The host supplies them on a byte-wide write port and then marks the end of the frame with a separate one-cycle strobe. The whole frame is held in an internal buffer. After the strobe, the block plays the frame out on a byte-wide valid/ready stream, and the final byte carries a last marker. Two mode inputs are sampled at the end-of-frame strobe. The first extends short frames with zero bytes up to the 60-byte minimum. The second appends a 32-bit frame check sequence.

The host may write only while the ready output is high. Ready falls while a frame is being played out and also whenever the buffer is full. Any write made while ready is low is dropped and flagged one cycle later. When a frame ends, a status code and a one-cycle event report the outcome. The code records either a sent frame or an end-of-frame strobe that arrived with an empty buffer. Preamble, collisions and retransmission are handled elsewhere.

Top module: `eth_tx_framer`

## Requirements
- R1: While `rst` is high, `tx_ready`, `out_valid`, `wr_reject` and `stat_event` are 0 and `stat_code` reads 0 (no status).
- R2: Writes made while `rst` is high are not stored: an end-of-frame after release reports underflow.
- R3: An end-of-frame strobe with a non-empty buffer drops `tx_ready` in the next cycle. The buffered bytes then leave on `out_data` in write order, one per cycle where `out_valid` and `out_ready` are both high.
- R4: When the pad mode (sampled at end-of-frame) is on and fewer than 60 bytes were written, zero bytes follow the data until 60 bytes have left, and only then does any check sequence follow.
- R5: A frame of 60 or more bytes is never padded, and no frame is padded when pad mode is off.
- R6: When check mode (sampled at end-of-frame) is on, four bytes follow the data and padding. They are the complement of a reflected CRC-32 (polynomial 0x04C11DB7, start value all ones) over those bytes, least-significant byte first. The ASCII bytes "123456789" give 26 39 F4 CB.
- R7: With check mode off, no check bytes are appended.
- R8: `out_last` is high on the final byte of each frame and on no other byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R10: After DEPTH (default 1514) accepted bytes, `tx_ready` is low. A further write is dropped and raises `wr_reject` for one cycle, and the frame sent holds exactly DEPTH bytes.
- R11: A write made while a frame is being sent raises `wr_reject` in the next cycle and does not appear in any frame.
- R12: In the cycle after the final byte is taken, `stat_event` pulses for one cycle, `stat_code` reads 1 (sent) and `tx_ready` is high again.
- R13: An end-of-frame strobe with an empty buffer pulses `stat_event` with `stat_code` 2 (underflow) and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pad_en | input | 1 | Pad short frames to 60 bytes, sampled at end-of-frame |
| cfg_crc_en | input | 1 | Append frame check sequence, sampled at end-of-frame |
| wr_en | input | 1 | Host byte write |
| wr_data | input | 8 | Host byte |
| eof_strobe | input | 1 | End of the host frame |
| tx_ready | output | 1 | Host may write |
| wr_reject | output | 1 | Previous-cycle write was dropped |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of frame |
| stat_code | output | 2 | 0 none, 1 sent, 2 underflow |
| stat_event | output | 1 | One-cycle pulse when status updates |

## Verification
The bench sends a 1-byte padded frame, a 20-byte frame with padding and the check sequence under irregular backpressure, and a 70-byte frame that must not be padded. A framer that counts padding from zero instead of from the data length would send too many bytes. A framer that leaves out the zero bytes when computing the CRC would send the wrong check bytes. The mode inputs are flipped just after end-of-frame, which catches a design that reads them live instead of sampling them. The bench also fills the buffer to DEPTH and pushes one more write, and it pushes a write in the middle of a frame. A design that stores either byte shows it in the frame that follows or in a missing underflow report. The known check value for "123456789" pins down the bit order and the byte order of the check sequence.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    localparam int          MIN_FRAME_LEN = 60;
    localparam int          FCS_BYTES     = 4;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        TX_FILL = 2'd0,
        TX_DATA = 2'd1,
        TX_PAD  = 2'd2,
        TX_FCS  = 2'd3
    } tx_state_e;

    typedef enum logic [1:0] {
        ST_NONE     = 2'd0,
        ST_SENT     = 2'd1,
        ST_UNDERRUN = 2'd2
    } tx_stat_e;

    typedef struct packed {
        logic pad;
        logic crc;
    } tx_cfg_t;

    // One byte of reflected CRC-32, lowest bit first
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_buf.sv
module eth_tx_buf #(
    parameter int DEPTH = 1514,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_acc,
    input  logic [7:0]    wr_data,
    input  logic          clr,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [AW-1:0] count,
    output logic          full
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_acc) mem[count] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  count <= '0;
        else if (wr_acc) count <= count + AW'(1);
    end

    assign full    = (count == AW'(DEPTH));
    assign rd_data = mem[rd_addr];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= AW'(DEPTH)); // R10

    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (rst)
        full && !clr |=> full); // R10

endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
    import eth_tx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] fcs
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init) crc_q <= CRC_SEED;
        else if (en)     crc_q <= crc32_step(crc_q, data);
    end

    assign fcs = ~crc_q;

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_tx_pkg::*;
#(
    parameter int DEPTH = 1514
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_pad_en,
    input  logic       cfg_crc_en,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       eof_strobe,
    output logic       tx_ready,
    output logic       wr_reject,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last,
    output logic [1:0] stat_code,
    output logic       stat_event
);

    localparam int SPAN = (DEPTH > MIN_FRAME_LEN) ? DEPTH : MIN_FRAME_LEN;
    localparam int LW   = $clog2(SPAN + 1);

    tx_state_e   state;
    tx_cfg_t     cfg_q;
    tx_stat_e    stat_q;
    logic [LW-1:0] pos;
    logic [LW-1:0] len;
    logic [1:0]    fidx;
    logic [LW-1:0] count;
    logic          full;
    logic [7:0]    rd_data;
    logic [31:0]   fcs;
    logic          wr_acc;
    logic          take;
    logic          frame_end;
    logic          short_frame;
    logic          data_end;
    logic          pad_end;

    assign tx_ready    = !rst && (state == TX_FILL) && !full;
    assign wr_acc      = wr_en && tx_ready;
    assign out_valid   = (state != TX_FILL);
    assign take        = out_valid && out_ready;
    assign short_frame = cfg_q.pad && (len < LW'(MIN_FRAME_LEN));
    assign data_end    = (pos == len - LW'(1));
    assign pad_end     = (pos == LW'(MIN_FRAME_LEN - 1));
    assign frame_end   = take && out_last;

    always_comb begin
        out_data = 8'h00;
        out_last = 1'b0;
        case (state)
            TX_DATA: begin
                out_data = rd_data;
                out_last = data_end && !short_frame && !cfg_q.crc;
            end
            TX_PAD: begin
                out_last = pad_end && !cfg_q.crc;
            end
            TX_FCS: begin
                out_data = fcs[8*fidx +: 8];
                out_last = (fidx == 2'(FCS_BYTES - 1));
            end
            default: ;
        endcase
    end

    eth_tx_buf #(.DEPTH(DEPTH), .AW(LW)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_acc  (wr_acc),
        .wr_data (wr_data),
        .clr     (frame_end),
        .rd_addr (pos),
        .rd_data (rd_data),
        .count   (count),
        .full    (full)
    );

    eth_tx_crc u_crc (
        .clk  (clk),
        .rst  (rst),
        .init (state == TX_FILL),
        .en   (take && (state != TX_FCS)),
        .data (out_data),
        .fcs  (fcs)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= TX_FILL;
            cfg_q      <= '0;
            stat_q     <= ST_NONE;
            stat_event <= 1'b0;
            wr_reject  <= 1'b0;
            pos        <= '0;
            len        <= '0;
            fidx       <= '0;
        end else begin
            stat_event <= 1'b0;
            wr_reject  <= wr_en && !tx_ready;
            case (state)
                TX_FILL: begin
                    if (eof_strobe) begin
                        if (count == '0 && !wr_acc) begin
                            stat_q     <= ST_UNDERRUN;
                            stat_event <= 1'b1;
                        end else begin
                            len   <= count + LW'(wr_acc);
                            cfg_q <= '{pad: cfg_pad_en, crc: cfg_crc_en};
                            pos   <= '0;
                            state <= TX_DATA;
                        end
                    end
                end
                TX_DATA: begin
                    if (take) begin
                        pos <= pos + LW'(1);
                        if (data_end) begin
                            if (short_frame)    state <= TX_PAD;
                            else if (cfg_q.crc) state <= TX_FCS;
                            else                state <= TX_FILL;
                            fidx <= '0;
                        end
                    end
                end
                TX_PAD: begin
                    if (take) begin
                        pos <= pos + LW'(1);
                        if (pad_end) begin
                            state <= cfg_q.crc ? TX_FCS : TX_FILL;
                            fidx  <= '0;
                        end
                    end
                end
                TX_FCS: begin
                    if (take) begin
                        fidx <= fidx + 2'd1;
                        if (out_last) state <= TX_FILL;
                    end
                end
                default: state <= TX_FILL;
            endcase
            if (frame_end) begin
                stat_q     <= ST_SENT;
                stat_event <= 1'b1;
            end
        end
    end

    assign stat_code = stat_q;

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !tx_ready); // R11

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        full |-> !tx_ready); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R8

    AST_DONE_REPORT: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> stat_event && stat_code == 2'd1 && tx_ready); // R12

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        state == TX_PAD |-> out_data == 8'h00); // R4

endmodule

// File: tb/eth_tx_framer_tb.sv
`timescale 1ns/1ps
module eth_tx_framer_tb;

    localparam int DEPTH = 1514;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_pad_en = 1'b0;
    logic       cfg_crc_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       eof_strobe = 1'b0;
    logic       out_ready = 1'b1;
    logic       tx_ready, wr_reject, out_valid, out_last, stat_event;
    logic [7:0] out_data;
    logic [1:0] stat_code;

    int checks = 0;
    int fails  = 0;

    logic [7:0] frm  [0:2047];
    logic [7:0] expb [0:2047];
    logic [7:0] gotb [0:2047];
    int nexp;
    int ngot;

    always #4 clk = ~clk;

    eth_tx_framer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .cfg_pad_en(cfg_pad_en), .cfg_crc_en(cfg_crc_en),
        .wr_en(wr_en), .wr_data(wr_data), .eof_strobe(eof_strobe),
        .tx_ready(tx_ready), .wr_reject(wr_reject), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .stat_code(stat_code), .stat_event(stat_event)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ expb[i][b]) c = (c >> 1) ^ 32'hEDB8_8320;
                else                   c = c >> 1;
            end
        end
        return ~c;
    endfunction

    task automatic build_expected(input int n, input bit pad, input bit crc);
        logic [31:0] f;
        nexp = n;
        for (int i = 0; i < n; i++) expb[i] = frm[i];
        if (pad) begin
            while (nexp < 60) begin expb[nexp] = 8'h00; nexp++; end
        end
        if (crc) begin
            f = ref_crc(nexp);
            for (int i = 0; i < 4; i++) begin expb[nexp] = f[8*i +: 8]; nexp++; end
        end
    endtask

    task automatic send_frame(input int n, input bit pad, input bit crc,
                              input bit stall, input bit inject, input string req);
        bit bad, lastbad, was_stall;
        logic [7:0] held;
        build_expected(n, pad, crc);
        cfg_pad_en = pad;
        cfg_crc_en = crc;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wr_en = 1'b1; wr_data = frm[i];
        end
        @(negedge clk); wr_en = 1'b0;
        if (n == DEPTH) begin
            chk(tx_ready == 1'b0, "R10", "ready when full", 32'(tx_ready), 0);
            wr_en = 1'b1; wr_data = 8'h5A;
            @(negedge clk); wr_en = 1'b0;
            chk(wr_reject == 1'b1, "R10", "reject on full write", 32'(wr_reject), 1);
        end
        eof_strobe = 1'b1;
        @(negedge clk); eof_strobe = 1'b0;
        cfg_pad_en = ~pad; cfg_crc_en = ~crc;
        chk(tx_ready == 1'b0, "R3", "ready after eof", 32'(tx_ready), 0);
        ngot = 0; bad = 0; lastbad = 0; was_stall = 0; held = 8'h00;
        for (int k = 0; k < 4000; k++) begin
            if (k > 0) @(negedge clk);
            if (was_stall)
                chk(out_valid && out_data == held, "R9", "hold under stall", 32'(out_data), 32'(held));
            out_ready = stall ? (k % 3 != 2) : 1'b1;
            wr_en = inject && (k == 5);
            wr_data = 8'hA5;
            #1;
            if (inject && k == 6)
                chk(wr_reject == 1'b1, "R11", "reject while busy", 32'(wr_reject), 1);
            if (out_valid && out_ready) begin
                if (ngot >= nexp || out_data !== expb[ngot]) bad = 1;
                if (out_last !== (ngot == nexp - 1)) lastbad = 1;
                gotb[ngot] = out_data;
                ngot++;
                if (out_last) break;
            end
            was_stall = out_valid && !out_ready;
            held = out_data;
        end
        wr_en = 1'b0;
        chk(ngot == nexp, req, "frame length", 32'(ngot), 32'(nexp));
        chk(!bad, req, "frame bytes match", 32'(bad), 0);
        chk(!lastbad, "R8", "last marker position", 32'(lastbad), 0);
        @(negedge clk); #1;
        out_ready = 1'b1;
        chk(stat_event == 1'b1 && stat_code == 2'd1, "R12", "sent status",
            {stat_event, stat_code}, 32'h5);
        chk(tx_ready == 1'b1 && out_valid == 1'b0, "R12", "ready again",
            {tx_ready, out_valid}, 32'h2);
        @(negedge clk); #1;
        chk(stat_event == 1'b0, "R12", "event one cycle", 32'(stat_event), 0);
    endtask

    task automatic send_empty_eof(input string req);
        @(negedge clk); eof_strobe = 1'b1;
        @(negedge clk); eof_strobe = 1'b0; #1;
        chk(stat_event == 1'b1 && stat_code == 2'd2, req, "underflow status",
            {stat_event, stat_code}, 32'h6);
        chk(out_valid == 1'b0, req, "nothing sent", 32'(out_valid), 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk); #1;
        chk(tx_ready == 0 && out_valid == 0 && wr_reject == 0 && stat_event == 0 && stat_code == 0,
            "R1", "reset outputs", {tx_ready, out_valid, wr_reject, stat_event, stat_code}, 0);
        wr_en = 1'b0;
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;
        chk(tx_ready == 1'b1, "R1", "ready after release", 32'(tx_ready), 1);
        send_empty_eof("R2");
    endtask

    task automatic t_known_vector;
        for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
        send_frame(9, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
        chk({gotb[12], gotb[11], gotb[10], gotb[9]} == 32'hCBF4_3926, "R6", "known check value",
            {gotb[12], gotb[11], gotb[10], gotb[9]}, 32'hCBF4_3926);
    endtask

    task automatic t_pad_crc_stall;
        for (int i = 0; i < 20; i++) frm[i] = 8'(i * 13 + 5);
        send_frame(20, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_single_pad;
        frm[0] = 8'hC3;
        send_frame(1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        chk(ngot == 60, "R4", "padded length", 32'(ngot), 60);
    endtask

    task automatic t_long_no_pad;
        for (int i = 0; i < 70; i++) frm[i] = 8'(255 - i * 3);
        send_frame(70, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
        chk(ngot == 74, "R5", "no pad on long frame", 32'(ngot), 74);
    endtask

    task automatic t_busy_write;
        for (int i = 0; i < 15; i++) frm[i] = 8'(i + 100);
        send_frame(15, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
        chk(ngot == 15, "R7", "no fcs no pad", 32'(ngot), 15);
        send_empty_eof("R13");
    endtask

    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) frm[i] = 8'(i ^ (i >> 8));
        send_frame(DEPTH, 1'b0, 1'b0, 1'b0, 1'b0, "R10");
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_known_vector();
        t_pad_crc_stall();
        t_single_pad();
        t_long_no_pad();
        t_busy_write();
        t_full();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule